// File: doc/BRIEF.md
# Issue-Driven ALU Computation Unit

This unit runs one arithmetic micro-operation at a time for a pipeline controller. A one-cycle issue pulse hands over an operation code and three modifier flags. The unit then does three things in order. It fetches up to two 16-bit source operands over two independent read ports. It passes the operands through an internal test ALU that has a valid/ready interface. It offers the 16-bit result on a write port. The busy output tells the controller when the unit can take the next operation.

Three modifier flags can reduce or change the operand traffic:
- The zero-A flag replaces the first operand with zero and skips the read on port A.
- The immediate-valid flag replaces the second operand with the issued immediate and skips the read on port B.
- The invert flag complements the first operand before it enters the ALU. This is applied after the zero-A substitution.

The internal ALU treats three codes as multi-cycle and every other code as zero-latency. All of them sit behind the same handshake.

Three 8-bit wrapping counters are debug observation points. They count completed reads on port A, completed reads on port B and accepted result writes.

Top module: `alu_issue_unit`

## Requirements
- R1: An issue pulse is accepted only while busy is low. busy is high from the edge that accepts the issue until the edge at which the result write is accepted. An issue pulse while busy is high does not change the result, the port traffic or the counters.
- R2: With zero-A set, read port A is never requested for that operation and the first operand is 0.
- R3: With immediate-valid set, read port B is never requested for that operation and the second operand is the issued immediate.
- R4: With invert set, the first operand (after any zero-A substitution) is bitwise complemented, so A=5 inverted plus B=2 gives 65532.
- R5: The 4-bit operation codes produce these results, all modulo 2^16:

  | Code | Operation | Result |
  |------|-----------|--------|
  | 0 | ADD | A+B |
  | 1 | MUL | low 16 bits of A*B |
  | 2 | SHR | A shifted right logically by B[3:0] |
  | any other | subtract | A-B |

- R6: When both operands are skipped and the write is accepted at once, the write request is visible after a fixed number of clock edges following the issue edge:

  | Operation | Edges after the issue edge |
  |-----------|----------------------------|
  | Subtract codes | 1 |
  | ADD | 2 |
  | SHR | 2 |
  | MUL | 3 |

- R7: An operand read request stays high until the port answers valid. The data is captured at the valid edge, and data on the port outside that cycle is ignored. Any number of wait cycles is allowed.
- R8: The write request and its data stay steady until the accept input is seen. Any number of wait cycles is allowed.
- R9: Each debug counter increments by one on each completed handshake of its port and wraps from 255 to 0.
- R10: Every accepted operation makes exactly one result write. It also makes exactly one read on each operand port that it does not skip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | One-cycle operation launch |
| op_i | input | 4 | Operation code |
| inv_a_i | input | 1 | Complement the first operand |
| zero_a_i | input | 1 | Use zero as the first operand and skip read A |
| imm_ok_i | input | 1 | Use the immediate as the second operand and skip read B |
| imm_i | input | 16 | Immediate value |
| busy_o | output | 1 | Operation in flight |
| rda_req_o | output | 1 | Read request, operand A |
| rda_valid_i | input | 1 | Read data valid, operand A |
| rda_data_i | input | 16 | Read data, operand A |
| rdb_req_o | output | 1 | Read request, operand B |
| rdb_valid_i | input | 1 | Read data valid, operand B |
| rdb_data_i | input | 16 | Read data, operand B |
| wr_req_o | output | 1 | Result write request |
| wr_ack_i | input | 1 | Result write accepted |
| wr_data_o | output | 16 | Result value |
| cnt_a_o | output | 8 | Completed A reads, wrapping |
| cnt_b_o | output | 8 | Completed B reads, wrapping |
| cnt_w_o | output | 8 | Accepted writes, wrapping |

## Verification
Two pairs of events can fall in the same cycle:
- The two operand ports can both complete in one cycle.
- For a zero-latency code, the ALU's input handshake and output handshake can both complete in one cycle.

The bench provokes the first pair by giving both port responders the same wait count. It provokes the second by issuing subtract codes, alone and with both operands skipped.

In each case the behavioural model judges the result against its own arithmetic. It also checks, every clock, that busy and the three counters match the handshakes it counted itself. The fixed edge count of R6 shows that the fused handshake costs no cycle.

// File: rtl/alu_issue_pkg.sv
package alu_issue_pkg;

  localparam int OPW = 4;

  localparam logic [OPW-1:0] OPC_ADD = 4'd0;
  localparam logic [OPW-1:0] OPC_MUL = 4'd1;
  localparam logic [OPW-1:0] OPC_SHR = 4'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_WRITE
  } unit_state_t;

  // Extra cycles an operation spends in the ALU; 0 means combinational.
  function automatic logic [1:0] op_latency(input logic [OPW-1:0] op);
    case (op)
      OPC_ADD: op_latency = 2'd1;
      OPC_MUL: op_latency = 2'd2;
      OPC_SHR: op_latency = 2'd1;
      default: op_latency = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/operand_fetch.sv
module operand_fetch #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          skip,
  input  logic [W-1:0]  skip_val,
  input  logic          rd_valid,
  input  logic [W-1:0]  rd_data,
  output logic          req,
  output logic [W-1:0]  data,
  output logic          have,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      have <= 1'b0;
      data <= '0;
      cnt  <= '0;
    end else if (start) begin
      req  <= !skip;
      have <= skip;
      data <= skip_val;
    end else if (req && rd_valid) begin
      req  <= 1'b0;
      have <= 1'b1;
      data <= rd_data;
      cnt  <= cnt + 1'b1;
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req && !rd_valid |=> req);

  // R7
  data_keep_chk: assert property (@(posedge clk) disable iff (rst)
    have && !start |=> have && $stable(data));

endmodule

// File: rtl/test_alu.sv
module test_alu
  import alu_issue_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] op,
  input  logic           inv,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_data
);

  localparam int SHW = $clog2(W);

  logic [W-1:0]   a_eff, calc;
  logic [2*W-1:0] prod;
  logic [1:0]     lat;
  logic           multi;
  logic           pend;
  logic [1:0]     wcnt;
  logic [W-1:0]   res_q;

  assign a_eff = inv ? ~a : a;
  assign prod  = a_eff * b;
  assign lat   = op_latency(op);
  assign multi = (lat != 2'd0);

  always_comb begin
    case (op)
      OPC_ADD: calc = a_eff + b;
      OPC_MUL: calc = prod[W-1:0];
      OPC_SHR: calc = a_eff >> b[SHW-1:0];
      default: calc = a_eff - b;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      wcnt  <= '0;
      res_q <= '0;
    end else if (in_valid && in_ready && multi) begin
      pend  <= 1'b1;
      wcnt  <= lat - 2'd1;
      res_q <= calc;
    end else if (pend) begin
      if (wcnt != 2'd0)  wcnt <= wcnt - 2'd1;
      else if (out_ready) pend <= 1'b0;
    end
  end

  assign in_ready  = !pend;
  assign out_valid = pend ? (wcnt == 2'd0) : (in_valid && !multi);
  assign out_data  = pend ? res_q : calc;

  // R5
  alu_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pend && out_valid && !out_ready |=> out_valid && $stable(out_data));

endmodule

// File: rtl/alu_issue_unit.sv
module alu_issue_unit
  import alu_issue_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           issue_i,
  input  logic [OPW-1:0] op_i,
  input  logic           inv_a_i,
  input  logic           zero_a_i,
  input  logic           imm_ok_i,
  input  logic [W-1:0]   imm_i,
  output logic           busy_o,
  output logic           rda_req_o,
  input  logic           rda_valid_i,
  input  logic [W-1:0]   rda_data_i,
  output logic           rdb_req_o,
  input  logic           rdb_valid_i,
  input  logic [W-1:0]   rdb_data_i,
  output logic           wr_req_o,
  input  logic           wr_ack_i,
  output logic [W-1:0]   wr_data_o,
  output logic [CW-1:0]  cnt_a_o,
  output logic [CW-1:0]  cnt_b_o,
  output logic [CW-1:0]  cnt_w_o
);

  localparam int NPORT = 2;

  unit_state_t    state;
  logic [OPW-1:0] op_q;
  logic           inv_q;
  logic           start;

  logic           p_skip  [NPORT];
  logic [W-1:0]   p_sval  [NPORT];
  logic           p_valid [NPORT];
  logic [W-1:0]   p_rdata [NPORT];
  logic           p_req   [NPORT];
  logic [W-1:0]   p_data  [NPORT];
  logic           p_have  [NPORT];
  logic [CW-1:0]  p_cnt   [NPORT];

  logic           alu_in_valid, alu_in_ready, alu_out_valid, alu_out_ready;
  logic [W-1:0]   alu_out_data;
  logic           in_fire, out_fire;
  logic [CW-1:0]  wcnt_q;

  assign start = issue_i && (state == ST_IDLE);

  assign p_skip[0]  = zero_a_i;
  assign p_sval[0]  = '0;
  assign p_valid[0] = rda_valid_i;
  assign p_rdata[0] = rda_data_i;
  assign p_skip[1]  = imm_ok_i;
  assign p_sval[1]  = imm_i;
  assign p_valid[1] = rdb_valid_i;
  assign p_rdata[1] = rdb_data_i;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    operand_fetch #(.W(W), .CW(CW)) i_fetch (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .skip     (p_skip[g]),
      .skip_val (p_sval[g]),
      .rd_valid (p_valid[g]),
      .rd_data  (p_rdata[g]),
      .req      (p_req[g]),
      .data     (p_data[g]),
      .have     (p_have[g]),
      .cnt      (p_cnt[g])
    );
  end

  assign alu_in_valid  = (state == ST_FETCH) && p_have[0] && p_have[1];
  assign alu_out_ready = (state == ST_FETCH) || (state == ST_EXEC);
  assign in_fire       = alu_in_valid && alu_in_ready;
  assign out_fire      = alu_out_valid && alu_out_ready;

  test_alu #(.W(W)) i_alu (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (alu_in_valid),
    .in_ready  (alu_in_ready),
    .op        (op_q),
    .inv       (inv_q),
    .a         (p_data[0]),
    .b         (p_data[1]),
    .out_valid (alu_out_valid),
    .out_ready (alu_out_ready),
    .out_data  (alu_out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= '0;
      inv_q     <= 1'b0;
      wr_req_o  <= 1'b0;
      wr_data_o <= '0;
      wcnt_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_FETCH;
          op_q  <= op_i;
          inv_q <= inv_a_i;
        end
        ST_FETCH: if (in_fire) begin
          if (out_fire) begin
            state     <= ST_WRITE;
            wr_req_o  <= 1'b1;
            wr_data_o <= alu_out_data;
          end else begin
            state <= ST_EXEC;
          end
        end
        ST_EXEC: if (out_fire) begin
          state     <= ST_WRITE;
          wr_req_o  <= 1'b1;
          wr_data_o <= alu_out_data;
        end
        default: if (wr_ack_i) begin
          state    <= ST_IDLE;
          wr_req_o <= 1'b0;
          wcnt_q   <= wcnt_q + 1'b1;
        end
      endcase
    end
  end

  assign busy_o    = (state != ST_IDLE);
  assign rda_req_o = p_req[0];
  assign rdb_req_o = p_req[1];
  assign cnt_a_o   = p_cnt[0];
  assign cnt_b_o   = p_cnt[1];
  assign cnt_w_o   = wcnt_q;

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_data_o));

  // R1
  busy_span_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o && !(wr_req_o && wr_ack_i) |=> busy_o);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !rda_req_o && !rdb_req_o && !wr_req_o);

  // R9
  wcount_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_req_o && wr_ack_i) |=> $stable(cnt_w_o));

endmodule

// File: tb/test_alu_issue_unit.sv
`timescale 1ns/1ps
module test_alu_issue_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        inv_a_i = 1'b0, zero_a_i = 1'b0, imm_ok_i = 1'b0;
  logic [15:0] imm_i = '0;
  logic        busy_o;
  logic        rda_req_o, rdb_req_o, wr_req_o;
  logic        rda_valid_i = 1'b0, rdb_valid_i = 1'b0, wr_ack_i = 1'b0;
  logic [15:0] rda_data_i = 16'hDEAD, rdb_data_i = 16'hBEEF, wr_data_o;
  logic [7:0]  cnt_a_o, cnt_b_o, cnt_w_o;

  int compared = 0, mismatched = 0, cycles = 0;
  int dly_a = 0, dly_b = 0, dly_w = 0;
  logic [15:0] val_a = '0, val_b = '0;
  bit cur_za = 0, cur_io = 0, m_busy = 0, done = 0;
  int mc_a = 0, mc_b = 0, mc_w = 0;
  int na = 0, nb = 0, nw = 0;

  always #2 clk = ~clk;

  alu_issue_unit i_alu_issue_unit (
    .clk(clk), .rst(rst), .issue_i(issue_i), .op_i(op_i), .inv_a_i(inv_a_i),
    .zero_a_i(zero_a_i), .imm_ok_i(imm_ok_i), .imm_i(imm_i), .busy_o(busy_o),
    .rda_req_o(rda_req_o), .rda_valid_i(rda_valid_i), .rda_data_i(rda_data_i),
    .rdb_req_o(rdb_req_o), .rdb_valid_i(rdb_valid_i), .rdb_data_i(rdb_data_i),
    .wr_req_o(wr_req_o), .wr_ack_i(wr_ack_i), .wr_data_o(wr_data_o),
    .cnt_a_o(cnt_a_o), .cnt_b_o(cnt_b_o), .cnt_w_o(cnt_w_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_res(input logic [3:0] op, input logic [15:0] a,
      input logic [15:0] b, input bit inv, input bit za, input bit io, input logic [15:0] imm);
    logic [15:0] av, bv;
    logic [31:0] p;
    av = za ? 16'd0 : a;
    if (inv) av = ~av;
    bv = io ? imm : b;
    p = av * bv;
    case (op)
      4'd0: return av + bv;
      4'd1: return p[15:0];
      4'd2: return av >> bv[3:0];
      default: return av - bv;
    endcase
  endfunction

  // behavioural model: busy flag and handshake tallies
  always @(posedge clk) begin
    if (rst) m_busy = 0;
    else begin
      if (rda_req_o && rda_valid_i) mc_a++;
      if (rdb_req_o && rdb_valid_i) mc_b++;
      if (wr_req_o && wr_ack_i) begin mc_w++; m_busy = 0; end
      else if (issue_i && !m_busy) m_busy = 1;
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      chk(busy_o == m_busy, "R1 busy", busy_o, m_busy);
      chk(cnt_a_o == mc_a[7:0], "R9 cnt_a", cnt_a_o, mc_a & 255);
      chk(cnt_b_o == mc_b[7:0], "R9 cnt_b", cnt_b_o, mc_b & 255);
      chk(cnt_w_o == mc_w[7:0], "R9 cnt_w", cnt_w_o, mc_w & 255);
      if (cur_za) chk(!rda_req_o, "R2 read A requested", rda_req_o, 0);
      if (cur_io) chk(!rdb_req_o, "R3 read B requested", rdb_req_o, 0);
    end
    if (cycles > 150000 && !done) begin
      done = 1;
      chk(0, "watchdog", cycles, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // operand and write responders (R7 and R8 wait cycles)
  initial begin : resp_a
    int w = 0;
    forever begin
      @(negedge clk);
      if (rda_valid_i) begin rda_valid_i = 0; rda_data_i = 16'hDEAD; w = 0; end
      else if (rda_req_o) begin
        if (w >= dly_a) begin rda_valid_i = 1; rda_data_i = val_a; end else w++;
      end
    end
  end

  initial begin : resp_b
    int w = 0;
    forever begin
      @(negedge clk);
      if (rdb_valid_i) begin rdb_valid_i = 0; rdb_data_i = 16'hBEEF; w = 0; end
      else if (rdb_req_o) begin
        if (w >= dly_b) begin rdb_valid_i = 1; rdb_data_i = val_b; end else w++;
      end
    end
  end

  initial begin : resp_w
    int w = 0;
    forever begin
      @(negedge clk);
      if (wr_ack_i) begin wr_ack_i = 0; w = 0; end
      else if (wr_req_o) begin
        if (w >= dly_w) wr_ack_i = 1; else w++;
      end
    end
  end

  task automatic do_op(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
      input bit inv, input bit za, input bit io, input logic [15:0] imm,
      input int da, input int db, input int dw, input bit poke, input string tag);
    logic [15:0] exp;
    int k, guard, lat;
    exp = ref_res(op, a, b, inv, za, io, imm);
    dly_a = da; dly_b = db; dly_w = dw; val_a = a; val_b = b;
    cur_za = za; cur_io = io;
    @(negedge clk);
    op_i = op; inv_a_i = inv; zero_a_i = za; imm_ok_i = io; imm_i = imm; issue_i = 1;
    @(negedge clk);
    issue_i = 0;
    k = 1; guard = 0;
    while (!wr_req_o && guard < 2000) begin
      if (poke && k == 2) begin
        // R1: a second issue while busy, with different fields
        op_i = 4'd5; inv_a_i = 1; zero_a_i = 0; imm_ok_i = 0; imm_i = 16'h1234; issue_i = 1;
      end
      if (poke && k == 3) issue_i = 0;
      @(negedge clk);
      k++; guard++;
    end
    issue_i = 0;
    chk(wr_data_o == exp, {tag, " result"}, wr_data_o, exp);
    if (za && io && dw == 0) begin
      lat = (op == 4'd1) ? 3 : (op == 4'd0 || op == 4'd2) ? 2 : 1;
      chk(k - 1 == lat, {"R6 latency ", tag}, k - 1, lat);
    end
    guard = 0;
    while (busy_o && guard < 2000) begin @(negedge clk); guard++; end
    nw++;
    if (!za) na++;
    if (!io) nb++;
    chk(mc_a == na, "R10 A reads", mc_a, na);
    chk(mc_b == nb, "R10 B reads", mc_b, nb);
    chk(mc_w == nw, "R10 writes", mc_w, nw);
    cur_za = 0; cur_io = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy_o && !rda_req_o && !rdb_req_o && !wr_req_o, "R1 reset outputs",
        {busy_o, rda_req_o, rdb_req_o, wr_req_o}, 0);
    chk(cnt_a_o == 0 && cnt_b_o == 0 && cnt_w_o == 0, "R9 reset counters",
        cnt_a_o + cnt_b_o + cnt_w_o, 0);

    do_op(4'd0, 5, 2, 0, 1, 1, 8, 0, 2, 0, 0, "R2 R3 zeroA+imm");
    do_op(4'd0, 5, 2, 0, 0, 1, 8, 2, 0, 2, 0, "R3 imm");
    do_op(4'd0, 5, 2, 0, 0, 0, 0, 1, 1, 1, 0, "R5 add");
    do_op(4'd0, 5, 2, 1, 0, 0, 0, 1, 2, 0, 0, "R4 invert");
    do_op(4'd0, 5, 2, 0, 1, 0, 0, 2, 0, 1, 0, "R2 zeroA");
    do_op(4'd7, 5, 2, 0, 0, 0, 0, 0, 1, 2, 0, "R5 sub");
    do_op(4'd3, 2, 5, 0, 0, 0, 0, 0, 0, 0, 0, "R5 sub wrap same-cycle");
    do_op(4'd1, 300, 300, 0, 0, 0, 0, 3, 3, 0, 0, "R5 mul");
    do_op(4'd2, 16'h8000, 16'h0013, 0, 0, 0, 0, 0, 4, 0, 0, "R5 shr");
    do_op(4'd0, 0, 7, 1, 1, 0, 0, 0, 0, 0, 0, "R4 zero+invert");
    do_op(4'd9, 0, 0, 0, 1, 1, 16'd4, 0, 0, 0, 0, "R6 simple");
    do_op(4'd0, 0, 0, 0, 1, 1, 16'd4, 0, 0, 0, 0, "R6 add");
    do_op(4'd2, 0, 0, 1, 1, 1, 16'd4, 0, 0, 0, 0, "R6 shr");
    do_op(4'd1, 0, 0, 1, 1, 1, 16'd3, 0, 0, 0, 0, "R6 mul");
    do_op(4'd0, 100, 23, 0, 0, 0, 0, 6, 5, 7, 0, "R7 R8 long waits");
    do_op(4'd1, 9, 11, 0, 0, 0, 0, 6, 6, 3, 1, "R1 issue while busy");
    for (int i = 0; i < 260; i++)
      do_op(4'd4, 0, 0, 0, 1, 1, 16'(i), 0, 0, i % 2, 0, "R9 wrap run");
    chk(nw > 255 && cnt_w_o == nw[7:0], "R9 write counter wrapped", cnt_w_o, nw & 255);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule